// File: doc/BRIEF.md
# Byte Arithmetic and Carry-Bit Logic Unit

This unit is the arithmetic and single-bit logic stage of an 8-bit accumulator machine. Each cycle it takes the accumulator byte, a second operand byte, one Boolean source bit and the current carry, auxiliary carry and overflow flags. It computes either a byte operation (add, add with carry, subtract with borrow, decimal adjust) or a one-bit operation that uses the carry flag as its accumulator. It does not fetch operands or sequence instructions.

All outputs are registered and appear one clock after the inputs are presented. The byte result is returned together with the new carry (CY), auxiliary carry (AC), overflow (OV) and parity (P) flags. Opcodes that are not assigned pass the accumulator and flags through unchanged, so a controller can hold the unit idle without a separate enable.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output register is cleared to 0 at that edge.
- R2: Opcode 0 (add) gives `res_q` = (acc + opnd) mod 256 one clock later; `cy_q` is the carry out of bit 7 and `cy_in` is ignored (01h + FFh gives 00h with CY=1; 55h + AAh gives FFh with CY=0).
- R3: Opcode 1 (add with carry) gives (acc + opnd + cy_in) mod 256, with `cy_q` set exactly when that sum exceeds 255.
- R4: Opcode 2 (subtract with borrow) gives (acc - opnd - cy_in) mod 256, with `cy_q` set exactly when acc < opnd + cy_in.
- R5: For opcodes 0 and 1, `ac_q` is the carry out of bit 3 of the sum; for opcode 2, `ac_q` is set when the low nibble of acc is below the low nibble of opnd plus cy_in.
- R6: For opcodes 0, 1 and 2, `ov_q` is set exactly when the signed two's-complement result lies outside -128..+127.
- R7: After every operation, `par_q` equals the XOR of the eight bits of `res_q`.
- R8: Opcode 3 (decimal adjust) first adds 06h when the low nibble of acc exceeds 9 or `ac_in` is set; it then adds 60h when the high nibble of that intermediate exceeds 9, `cy_in` is set, or the first addition carried out of bit 7; `ac_q` and `ov_q` copy `ac_in` and `ov_in`.
- R9: Under opcode 3, `cy_q` is set if `cy_in` was set or either correction carried out of bit 7, and is otherwise cleared; it is never cleared when `cy_in` was set.
- R10: Opcodes 4..8 alter only the carry: 4 gives CY AND bit, 5 gives CY OR bit, 6 inverts CY, 7 sets CY, 8 clears CY; `res_q` returns acc and `ac_q`, `ov_q` copy their inputs.
- R11: Opcodes 9..15 return acc on `res_q` and copy `cy_in`, `ac_in`, `ov_in` to the flag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 4 | Operation select |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second byte operand |
| bit_in | input | 1 | Boolean source bit |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| ov_in | input | 1 | Current overflow flag |
| res_q | output | 8 | Registered byte result |
| cy_q | output | 1 | Registered carry flag |
| ac_q | output | 1 | Registered auxiliary carry flag |
| ov_q | output | 1 | Registered overflow flag |
| par_q | output | 1 | Registered parity of the result |

## Verification
The two decimal-adjust corrections can both fire in the same cycle, and the first can carry out and so force the second. The bench sweeps every accumulator byte against all four combinations of incoming CY and AC under opcode 3, which reaches bytes such as FAh and 9Ah where the low fix-up, the high fix-up and the carry out all fall together. Each result is judged against an integer model of the R8 and R9 rule that is computed separately from the design.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDC = 4'd1;
  localparam logic [3:0] OP_SUBB = 4'd2;
  localparam logic [3:0] OP_DA   = 4'd3;
  localparam logic [3:0] OP_BAND = 4'd4;
  localparam logic [3:0] OP_BOR  = 4'd5;
  localparam logic [3:0] OP_BCPL = 4'd6;
  localparam logic [3:0] OP_BSET = 4'd7;
  localparam logic [3:0] OP_BCLR = 4'd8;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              use_cin,
  input  logic              is_sub,
  output logic [DATA_W-1:0] res,
  output alu8_pkg::flags_t  flg
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [DATA_W:0]   full;
  logic [HALF_W:0]   low;

  always_comb begin
    b_eff = is_sub ? ~b : b;
    c_eff = is_sub ? ~(cin & use_cin) : (cin & use_cin);
    full  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
    low   = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]} + {{HALF_W{1'b0}}, c_eff};
    res    = full[DATA_W-1:0];
    flg.cy = full[DATA_W] ^ is_sub;
    flg.ac = low[HALF_W] ^ is_sub;
    flg.ov = (a[DATA_W-1] == b_eff[DATA_W-1]) && (full[DATA_W-1] != a[DATA_W-1]);
  end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cy_in,
  input  logic              ac_in,
  output logic [DATA_W-1:0] res,
  output logic              cy_out
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [HALF_W-1:0] DIGIT_MAX = HALF_W'(9);
  localparam logic [DATA_W:0]   LO_ADJ = (DATA_W+1)'(6);
  localparam logic [DATA_W:0]   HI_ADJ = LO_ADJ << HALF_W;

  logic            lo_fix, hi_fix;
  logic [DATA_W:0] step1, step2;

  always_comb begin
    lo_fix = (a[HALF_W-1:0] > DIGIT_MAX) || ac_in;
    step1  = {1'b0, a} + (lo_fix ? LO_ADJ : '0);
    hi_fix = (step1[DATA_W-1:HALF_W] > DIGIT_MAX) || cy_in || step1[DATA_W];
    step2  = {1'b0, step1[DATA_W-1:0]} + (hi_fix ? HI_ADJ : '0);
    res    = step2[DATA_W-1:0];
    cy_out = cy_in | step1[DATA_W] | step2[DATA_W];
  end
endmodule

// File: rtl/alu8_bitop.sv
module alu8_bitop (
  input  logic [3:0] op,
  input  logic       cy_in,
  input  logic       bit_in,
  output logic       cy_out
);
  import alu8_pkg::*;

  always_comb begin
    case (op)
      OP_BAND: cy_out = cy_in & bit_in;
      OP_BOR:  cy_out = cy_in | bit_in;
      OP_BCPL: cy_out = ~cy_in;
      OP_BSET: cy_out = 1'b1;
      OP_BCLR: cy_out = 1'b0;
      default: cy_out = cy_in;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic              bit_in,
  input  logic              cy_in,
  input  logic              ac_in,
  input  logic              ov_in,
  output logic [DATA_W-1:0] res_q,
  output logic              cy_q,
  output logic              ac_q,
  output logic              ov_q,
  output logic              par_q
);
  import alu8_pkg::*;

  logic [DATA_W-1:0] as_res, da_res, nxt_res;
  flags_t            as_flg, nxt_flg;
  logic              da_cy, bo_cy;
  logic              is_sub, use_cin, is_bit;

  assign is_sub  = (op_code == OP_SUBB);
  assign use_cin = (op_code == OP_ADDC) || (op_code == OP_SUBB);
  assign is_bit  = (op_code >= OP_BAND) && (op_code <= OP_BCLR);

  alu8_addsub #(.DATA_W(DATA_W)) addsub_i (
    .a(acc_in), .b(opnd_in), .cin(cy_in), .use_cin(use_cin),
    .is_sub(is_sub), .res(as_res), .flg(as_flg)
  );

  alu8_decadj #(.DATA_W(DATA_W)) decadj_i (
    .a(acc_in), .cy_in(cy_in), .ac_in(ac_in), .res(da_res), .cy_out(da_cy)
  );

  alu8_bitop bitop_i (
    .op(op_code), .cy_in(cy_in), .bit_in(bit_in), .cy_out(bo_cy)
  );

  always_comb begin
    nxt_res = acc_in;
    nxt_flg = '{cy: cy_in, ac: ac_in, ov: ov_in};
    if (op_code <= OP_SUBB) begin
      nxt_res = as_res;
      nxt_flg = as_flg;
    end else if (op_code == OP_DA) begin
      nxt_res    = da_res;
      nxt_flg.cy = da_cy;
    end else if (is_bit) begin
      nxt_flg.cy = bo_cy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      cy_q  <= 1'b0;
      ac_q  <= 1'b0;
      ov_q  <= 1'b0;
      par_q <= 1'b0;
    end else begin
      res_q <= nxt_res;
      cy_q  <= nxt_flg.cy;
      ac_q  <= nxt_flg.ac;
      ov_q  <= nxt_flg.ov;
      par_q <= ^nxt_res;
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (res_q == '0 && !cy_q && !ac_q && !ov_q && !par_q)); // R1
  AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_code) == OP_ADD) |-> ({cy_q, res_q} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)}))); // R2
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_code) == OP_SUBB) |-> (cy_q == ({1'b0, $past(acc_in)} < ({1'b0, $past(opnd_in)} + (DATA_W+1)'($past(cy_in)))))); // R4
  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
    armed |-> (par_q == ^res_q)); // R7
  AST_DA_CY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_code) == OP_DA && $past(cy_in)) |-> cy_q); // R9
  AST_BIT_KEEPS_BYTE: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_code) >= OP_BAND && $past(op_code) <= OP_BCLR) |->
      (res_q == $past(acc_in) && ac_q == $past(ac_in) && ov_q == $past(ov_in))); // R10
  AST_BSET_SETS: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_code) == OP_BSET) |-> cy_q); // R10
  AST_IDLE_PASSES: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_code) > OP_BCLR) |->
      (res_q == $past(acc_in) && cy_q == $past(cy_in) && ac_q == $past(ac_in) && ov_q == $past(ov_in))); // R11
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_code = '0;
  logic [7:0] acc_in = '0, opnd_in = '0;
  logic       bit_in = 1'b0, cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
  logic [7:0] res_q;
  logic       cy_q, ac_q, ov_q, par_q;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst(rst), .op_code(op_code), .acc_in(acc_in), .opnd_in(opnd_in),
    .bit_in(bit_in), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .res_q(res_q), .cy_q(cy_q), .ac_q(ac_q), .ov_q(ov_q), .par_q(par_q)
  );

  bit    pend = 1'b0;
  int    e_res;
  bit    e_cy, e_ac, e_ov, e_p;
  string e_tag;

  function automatic bit par8(int v);
    bit p = 1'b0;
    for (int i = 0; i < 8; i++) p ^= v[i];
    return p;
  endfunction

  function automatic int sx(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic compare();
    checks++;
    if (res_q !== e_res[7:0] || cy_q !== e_cy || ac_q !== e_ac || ov_q !== e_ov || par_q !== e_p) begin
      errors++;
      $display("FAIL %s: got res=%02h cy=%0b ac=%0b ov=%0b p=%0b, expected res=%02h cy=%0b ac=%0b ov=%0b p=%0b",
               e_tag, res_q, cy_q, ac_q, ov_q, par_q, e_res[7:0], e_cy, e_ac, e_ov, e_p);
    end
  endtask

  task automatic step(input int op, input int a, input int b, input bit bt,
                      input bit c, input bit ac, input bit ov);
    int s, t;
    bit cc;
    @(negedge clk);
    if (pend) compare();
    e_res = a; e_cy = c; e_ac = ac; e_ov = ov;
    case (op)
      0, 1: begin
        cc    = (op == 1) ? c : 1'b0;
        s     = a + b + int'(cc);
        e_res = s % 256;
        e_cy  = (s > 255);
        e_ac  = ((a % 16) + (b % 16) + int'(cc)) > 15;
        t     = sx(a) + sx(b) + int'(cc);
        e_ov  = (t > 127) || (t < -128);
        e_tag = (op == 0) ? "R2/R5/R6/R7" : "R3/R5/R6/R7";
      end
      2: begin
        s     = a - b - int'(c);
        e_res = (s + 256) % 256;
        e_cy  = (s < 0);
        e_ac  = ((a % 16) - (b % 16) - int'(c)) < 0;
        t     = sx(a) - sx(b) - int'(c);
        e_ov  = (t > 127) || (t < -128);
        e_tag = "R4/R5/R6/R7";
      end
      3: begin
        t  = a;
        cc = c;
        if ((a % 16) > 9 || ac) t = t + 6;
        if (t > 255) begin cc = 1'b1; t = t - 256; end
        if ((t / 16) > 9 || cc) t = t + 96;
        if (t > 255) begin cc = 1'b1; t = t - 256; end
        e_res = t; e_cy = cc;
        e_tag = "R8/R9";
      end
      4: begin e_cy = c & bt; e_tag = "R10 and"; end
      5: begin e_cy = c | bt; e_tag = "R10 or"; end
      6: begin e_cy = ~c;     e_tag = "R10 cpl"; end
      7: begin e_cy = 1'b1;   e_tag = "R10 set"; end
      8: begin e_cy = 1'b0;   e_tag = "R10 clr"; end
      default: e_tag = "R11";
    endcase
    e_p = par8(e_res);
    op_code = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0];
    bit_in = bt; cy_in = c; ac_in = ac; ov_in = ov;
    pend = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) compare();
    pend = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    op_code = 4'd1; acc_in = 8'h7F; opnd_in = 8'h9C; cy_in = 1'b1; ac_in = 1'b1; ov_in = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (res_q !== 8'h00 || cy_q || ac_q || ov_q || par_q) begin
      errors++;
      $display("FAIL R1: got res=%02h cy=%0b ac=%0b ov=%0b p=%0b, expected all zero",
               res_q, cy_q, ac_q, ov_q, par_q);
    end
    rst = 1'b0;

    step(0, 8'h01, 8'hFF, 0, 1, 0, 0);   // R2 wrap to 00 with carry, cy_in ignored
    step(0, 8'h55, 8'hAA, 0, 1, 1, 1);   // R2 FF without carry
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 3) step(0, a, b, 0, b[1], 0, 0);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5) step(1, a, b, 0, a[0] ^ b[0], 0, 0);
    step(1, 8'hFF, 8'h00, 0, 1, 0, 0);   // R3 carry-in alone wraps
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) step(2, a, b, 0, a[0] ^ b[1], 0, 0);
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 4; k++) step(3, a, 0, 0, k[0], k[1], k[0] ^ k[1]);
    for (int op = 4; op <= 8; op++)
      for (int k = 0; k < 8; k++) step(op, 8'h3C + k * 17, 0, k[0], k[1], k[2], ~k[0]);
    for (int op = 9; op <= 15; op++)
      for (int k = 0; k < 4; k++) step(op, 8'hA5 ^ (k * 37), 8'h5A, 1, k[0], k[1], ~k[0]);
    flush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule